// File: doc/BRIEF.md
# Configurable SPI Master Controller

This block is a register-programmed SPI master. A small word-addressed register port gives access to five registers: a packed configuration word, an event word, an event mask, a transmit data register and a receive data register. The configuration word selects the idle level of the serial clock, the sampling phase and the bit order. It also holds an internal loop-back switch, master and run enables, a character length from 4 to 16 bits or 32 bits, and a two-stage clock divider. That divider is an optional divide-by-16 prescaler followed by a 4-bit modulus.

Software writes one word to the transmit register. It is held in a one-entry buffer and moves into the shifter as soon as the shifter is free. The shifter then exchanges one character on the serial clock, data-out and data-in pins. When the character completes, the received bits are stored right-aligned in the receive register and a not-empty event is raised. A not-full event is raised when a held word moves into the shifter. Both events are latched, cleared by writing one, and can be masked onto a single interrupt line.

To change the configuration, software clears the run enable, rewrites the fields and then sets the run enable again. Clearing the run enable abandons any character that is in flight.

Top module: `spi_master_ctl`

## Requirements
- R1: The configuration register is at address 0. Loop-back is bit 30, clock-idle-high is bit 29, phase is bit 28, divide-by-16 is bit 27, MSB-first is bit 26, master is bit 25 and run enable is bit 24. The length code is bits 23:20 and the divider modulus PM is bits 19:16. It reads back exactly the bits written in 30:16 and reads 0 in all other bits. It reads 0 after reset.
- R2: Each half period of the serial clock lasts 2 × (PM+1) input clock cycles. When divide-by-16 is set, it lasts 32 × (PM+1) cycles.
- R3: The serial clock rests at the clock-idle-high value whenever no character is being shifted, including just after reset (0).
- R4: With phase 0, each bit is presented before the leading clock edge and both sides sample on the leading edge. With phase 1, each bit is presented on the leading edge and sampled on the trailing edge. A slave built on the same convention receives and returns every bit correctly in all four combinations of clock idle level and phase.
- R5: With MSB-first set, bit N-1 of the character goes out first and the first bit received becomes bit N-1. With MSB-first clear, bit 0 goes out first and the first bit received becomes bit 0.
- R6: A length code L from 3 to 15 gives L+1 bits per character. Code 0 gives 32 bits. Codes 1 and 2 give 4 bits.
- R7: After the last bit of a character, the received bits appear right-aligned in the receive register at address 4, with the upper bits 0, and the not-empty event (bit 9 of the event register) is set.
- R8: With loop-back set, the receiver takes the transmitted bits internally, the data-in pin has no effect, and the data-out pin still carries the character.
- R9: The event register is at address 1 and the mask register at address 2, both with not-empty at bit 9 and not-full at bit 8. Writing 1 to an event bit clears it and writing 0 leaves it unchanged. The interrupt output is the OR of event AND mask and follows the registers one cycle later.
- R10: A transmit write is at address 3. It is accepted only while the controller runs and the one-word holding buffer is empty, and an accepted write clears not-full. Not-full is set when the held word enters the shifter. A write made while a word is already held is dropped. A word written while the previous character is still shifting is sent right after it.
- R11: The controller runs only while both run enable and master are 1. While it is stopped, transmit writes are dropped. Stopping it during a character abandons that character: the serial clock returns to its idle level and not-empty is not set.
- R12: A read strobe at address A returns the register contents on the read data port in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| irq | output | 1 | Interrupt, OR of masked events |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest situations to reach from the ports are the ones tied to a moment inside a character. One is a controller stopped partway through a character. The other is a second word that must sit in the holding buffer while the first is still being shifted. The bench reaches both by slowing the serial clock with the divider modulus, so that there are tens of input cycles per bit. It then issues the disable, or the second and third transmit writes, at a known cycle offset after the first write. A bench-side slave that follows the phase rules records every bit on the data-out pin and drives the data-in pin. This lets the abandoned character be seen as a partial bit count with no not-empty event.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;

  localparam int REG_W     = 32;
  localparam int LEN_W     = 4;
  localparam int PMOD_W    = 4;
  localparam int CFG_LSB   = 16;
  localparam int CFG_MSB   = 30;
  localparam int EV_NE_BIT = 9;
  localparam int EV_NF_BIT = 8;

  typedef enum logic [2:0] {
    ADR_CFG  = 3'd0,
    ADR_EVT  = 3'd1,
    ADR_MASK = 3'd2,
    ADR_TX   = 3'd3,
    ADR_RX   = 3'd4
  } reg_adr_e;

  // packed in the same order as configuration bits 30 down to 16
  typedef struct packed {
    logic              loopback;
    logic              idle_high;
    logic              phase;
    logic              slow;
    logic              msb_first;
    logic              master;
    logic              enable;
    logic [LEN_W-1:0]  len_code;
    logic [PMOD_W-1:0] modulus;
  } cfg_t;

  // number of bits per character for a given length code
  function automatic logic [5:0] char_bits(input logic [LEN_W-1:0] code);
    logic [5:0] n;
    if (code == '0)          n = 6'd32;
    else if (code < 4'd3)    n = 6'd4;
    else                     n = {2'b00, code} + 6'd1;
    return n;
  endfunction

endpackage

// File: rtl/spi_sck_divider.sv
module spi_sck_divider #(
  parameter int PM_W     = 4,
  parameter int PRESCALE = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            slow,
  input  logic [PM_W-1:0] modulus,
  output logic            tick
);
  localparam int MAX_HALF = 2 * (2 ** PM_W) * PRESCALE;
  localparam int CNT_W    = $clog2(MAX_HALF);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   half_len;

  assign half_len = slow ? (CNT_W+1)'((modulus + 1) * 2 * PRESCALE)
                         : (CNT_W+1)'((modulus + 1) * 2);
  assign tick = en && ({1'b0, cnt_q} == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || !en || tick) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 32,
  localparam int BITS_W = $clog2(DATA_W) + 1,
  localparam int EDGE_W = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              idle_high,
  input  logic              phase,
  input  logic              msb_first,
  input  logic              loopback,
  input  logic [BITS_W-1:0] nbits,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  logic [EDGE_W-1:0] edge_q;
  logic [DATA_W-1:0] txsh_q, rxsh_q, load_val;
  logic [EDGE_W:0]   last_idx;
  logic [BITS_W-1:0] pad;
  logic              last_edge, leading, sample_now, drive_now, rx_in;
  logic              sck_q, mosi_q, busy_q, done_q;

  function automatic logic head_bit(input logic [DATA_W-1:0] v, input logic msb);
    return msb ? v[DATA_W-1] : v[0];
  endfunction

  function automatic logic [DATA_W-1:0] advance(input logic [DATA_W-1:0] v, input logic msb);
    return msb ? (v << 1) : (v >> 1);
  endfunction

  assign pad        = BITS_W'(DATA_W) - nbits;
  assign load_val   = msb_first ? (start_data << pad) : start_data;
  assign last_idx   = {nbits, 1'b0} - 1'b1;
  assign last_edge  = ({1'b0, edge_q} == last_idx);
  assign leading    = ~edge_q[0];
  assign sample_now = leading ^ phase;
  assign drive_now  = phase ? leading : (~leading & ~last_edge);
  assign rx_in      = loopback ? mosi_q : miso;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      edge_q <= '0;
      txsh_q <= '0;
      rxsh_q <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!run) begin
        busy_q <= 1'b0;
        edge_q <= '0;
        sck_q  <= idle_high;
        mosi_q <= 1'b0;
      end else if (start && !busy_q) begin
        busy_q <= 1'b1;
        edge_q <= '0;
        rxsh_q <= '0;
        sck_q  <= idle_high;
        if (!phase) begin
          mosi_q <= head_bit(load_val, msb_first);
          txsh_q <= advance(load_val, msb_first);
        end else begin
          txsh_q <= load_val;
        end
      end else if (busy_q && tick) begin
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 1'b1;
        if (sample_now)
          rxsh_q <= msb_first ? {rxsh_q[DATA_W-2:0], rx_in} : {rx_in, rxsh_q[DATA_W-1:1]};
        if (drive_now) begin
          mosi_q <= head_bit(txsh_q, msb_first);
          txsh_q <= advance(txsh_q, msb_first);
        end
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (!busy_q) begin
        sck_q <= idle_high;
      end
    end
  end

  assign rx_word = msb_first ? rxsh_q : (rxsh_q >> pad);
  assign busy    = busy_q;
  assign done    = done_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_ctl_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  localparam int BITS_W = $clog2(REG_W) + 1;

  cfg_t             cfg_q;
  logic             evt_ne_q, evt_nf_q, irq_q;
  logic [1:0]       mask_q;
  logic [REG_W-1:0] hold_q, rx_q, rdata_q, eng_rx;
  logic             hold_full_q;
  logic             run, cpol_w, sck_tick, eng_busy, eng_done, start, tx_accept;
  logic             wr_cfg, wr_evt, wr_mask, wr_tx;
  logic [BITS_W-1:0] nbits;

  assign run       = cfg_q.enable & cfg_q.master;
  assign cpol_w    = cfg_q.idle_high;
  assign nbits     = char_bits(cfg_q.len_code);
  assign wr_cfg    = reg_wr && (reg_addr == ADR_CFG);
  assign wr_evt    = reg_wr && (reg_addr == ADR_EVT);
  assign wr_mask   = reg_wr && (reg_addr == ADR_MASK);
  assign wr_tx     = reg_wr && (reg_addr == ADR_TX);
  assign tx_accept = wr_tx && run && !hold_full_q;
  assign start     = run && hold_full_q && !eng_busy;

  spi_sck_divider #(.PM_W(PMOD_W), .PRESCALE(PRESCALE)) u_div (
    .clk     (clk),
    .rst     (rst),
    .en      (eng_busy),
    .slow    (cfg_q.slow),
    .modulus (cfg_q.modulus),
    .tick    (sck_tick)
  );

  spi_shift_engine #(.DATA_W(REG_W)) u_eng (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .idle_high  (cfg_q.idle_high),
    .phase      (cfg_q.phase),
    .msb_first  (cfg_q.msb_first),
    .loopback   (cfg_q.loopback),
    .nbits      (nbits),
    .start      (start),
    .start_data (hold_q),
    .tick       (sck_tick),
    .miso       (miso),
    .busy       (eng_busy),
    .done       (eng_done),
    .rx_word    (eng_rx),
    .sck        (sck),
    .mosi       (mosi)
  );

  // configuration and mask
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '0;
    end else begin
      if (wr_cfg)  cfg_q  <= cfg_t'(reg_wdata[CFG_MSB:CFG_LSB]);
      if (wr_mask) mask_q <= {reg_wdata[EV_NE_BIT], reg_wdata[EV_NF_BIT]};
    end
  end

  // holding buffer and receive register
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rx_q        <= '0;
    end else begin
      if (!run || start) hold_full_q <= 1'b0;
      if (tx_accept) begin
        hold_q      <= reg_wdata;
        hold_full_q <= 1'b1;
      end
      if (eng_done) rx_q <= eng_rx;
    end
  end

  // events: set wins over a write-one clear
  always_ff @(posedge clk) begin
    if (rst) begin
      evt_ne_q <= 1'b0;
      evt_nf_q <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      evt_ne_q <= (evt_ne_q & ~(wr_evt & reg_wdata[EV_NE_BIT])) | eng_done;
      evt_nf_q <= (evt_nf_q & ~(wr_evt & reg_wdata[EV_NF_BIT]) & ~tx_accept) | start;
      irq_q    <= |({evt_ne_q, evt_nf_q} & mask_q);
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        ADR_CFG:  rdata_q <= {1'b0, cfg_q, 16'h0000};
        ADR_EVT:  rdata_q <= {22'd0, evt_ne_q, evt_nf_q, 8'h00};
        ADR_MASK: rdata_q <= {22'd0, mask_q, 8'h00};
        ADR_RX:   rdata_q <= rx_q;
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/spi_master_ctl_chk.sv
module spi_master_ctl_chk (
  input logic       clk,
  input logic       rst,
  input logic       run,
  input logic       cpol,
  input logic       sck,
  input logic       tick,
  input logic       eng_busy,
  input logic       eng_done,
  input logic       evt_ne,
  input logic       evt_nf,
  input logic [1:0] mask,
  input logic       irq
);
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    (!run && $past(!run) && $stable(cpol)) |-> (sck == cpol));

  assert_sck_paced_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(eng_busy) && $past(run)) |-> ($stable(sck) || $past(tick)));

  assert_ne_from_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_ne) |-> $past(eng_done));

  assert_nf_on_load_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_nf) |-> $rose(eng_busy));

  assert_mask_gates_irq_R9: assert property (@(posedge clk) disable iff (rst)
    (mask == 2'b00 && $past(mask) == 2'b00) |-> !irq);

  assert_busy_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
    eng_busy |-> $past(run));
endmodule

bind spi_master_ctl spi_master_ctl_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run),
  .cpol     (cpol_w),
  .sck      (sck),
  .tick     (sck_tick),
  .eng_busy (eng_busy),
  .eng_done (eng_done),
  .evt_ne   (evt_ne_q),
  .evt_nf   (evt_nf_q),
  .mask     (mask_q),
  .irq      (irq)
);

// File: tb/test_spi_master_ctl.sv
`timescale 1ns/1ps
module test_spi_master_ctl;
  logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, reg_rd = 1'b0, miso = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, sck, mosi;

  int checks = 0, errors = 0, cyc = 0;
  logic        b_cpol = 1'b0, b_cpha = 1'b0, b_msb = 1'b1, slv_on = 1'b0;
  logic [31:0] slv_word = 32'd0, slv_got = 32'd0;
  int          slv_idx = 0, slv_cnt = 0, slv_n = 8;

  spi_master_ctl i_spi_master_ctl (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .sck(sck),
    .mosi(mosi), .miso(miso)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic obit(input logic [31:0] w, input int k, input int n, input logic msb);
    if (k >= n) return 1'b0;
    return msb ? w[n-1-k] : w[k];
  endfunction

  function automatic logic [31:0] nmask(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
  endfunction

  function automatic logic [31:0] mw(input logic lp, input logic cp, input logic ph,
      input logic dv, input logic msb, input logic mst, input logic en,
      input logic [3:0] len, input logic [3:0] pm);
    return {1'b0, lp, cp, ph, dv, msb, mst, en, len, pm, 16'h0000};
  endfunction

  // slave model following the phase rules of R4
  always @(sck) begin
    if (slv_on) begin
      if ((sck != b_cpol) ^ b_cpha) begin
        if (b_msb) slv_got = {slv_got[30:0], mosi};
        else if (slv_cnt < 32) slv_got[slv_cnt] = mosi;
        slv_cnt = slv_cnt + 1;
      end else begin
        miso = obit(slv_word, slv_idx, slv_n, b_msb);
        slv_idx = slv_idx + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic wait_ne(output logic seen);
    logic [31:0] ev;
    seen = 1'b0;
    for (int i = 0; i < 4000 && !seen; i++) begin
      bus_rd(3'd1, ev);
      if (ev[9]) seen = 1'b1;
    end
  endtask

  task automatic configure(input logic lp, input logic dv, input logic [3:0] lf, input logic [3:0] pm);
    bus_wr(3'd0, mw(lp, b_cpol, b_cpha, dv, b_msb, 1'b1, 1'b0, lf, pm));
    bus_wr(3'd0, mw(lp, b_cpol, b_cpha, dv, b_msb, 1'b1, 1'b1, lf, pm));
  endtask

  task automatic xfer(input logic [31:0] tx, input logic [31:0] sp, input int n,
                      input logic lp, input logic clr, input string tag);
    logic        seen;
    logic [31:0] r;
    slv_word = sp; slv_n = n; slv_cnt = 0; slv_got = 32'd0;
    slv_idx  = b_cpha ? 0 : 1;
    miso     = b_cpha ? 1'b0 : obit(sp, 0, n, b_msb);
    slv_on   = 1'b1;
    bus_wr(3'd3, tx);
    wait_ne(seen);
    slv_on = 1'b0;
    chk({tag, " R7 not-empty"}, {31'd0, seen}, 32'd1);
    bus_rd(3'd4, r);
    chk({tag, " R7 rx word"}, r, lp ? (tx & nmask(n)) : (sp & nmask(n)));
    chk({tag, " R4 R5 mosi word"}, slv_got & nmask(n), tx & nmask(n));
    chk({tag, " R6 bit count"}, slv_cnt, n);
    if (clr) bus_wr(3'd1, 32'h0000_0300);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, tx, sp;
    logic        seen;
    int          n, t0, t1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    bus_rd(3'd0, r); chk("R1 cfg after reset", r, 32'd0);
    bus_rd(3'd1, r); chk("R9 events after reset", r, 32'd0);
    chk("R9 irq after reset", {31'd0, irq}, 32'd0);
    chk("R3 sck after reset", {31'd0, sck}, 32'd0);

    // R1 readback of defined bits only
    bus_wr(3'd0, 32'hFFFF_FFFF);
    bus_rd(3'd0, r); chk("R1 cfg readback", r, 32'h7FFF_0000);
    bus_wr(3'd0, 32'h0000_0000);
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_rd(3'd2, r); chk("R12 mask readback", r, 32'h0000_0300);
    bus_wr(3'd2, 32'd0);
    @(negedge clk);
    chk("R3 sck idle low", {31'd0, sck}, 32'd0);

    // sweep all modes and all length codes
    for (int m = 0; m < 8; m++) begin
      for (int lf = 0; lf < 16; lf++) begin
        b_cpol = m[0]; b_cpha = m[1]; b_msb = m[2];
        n  = (lf == 0) ? 32 : ((lf < 3) ? 4 : lf + 1);
        tx = 32'h6B3D_91C7 ^ (m * 32'h0123_4567) ^ (lf * 32'h9E37_79B9);
        sp = tx * 32'd7 + 32'h5A5A_1234;
        configure(1'b0, 1'b0, 4'(lf), 4'd0);
        xfer(tx, sp, n, 1'b0, 1'b1, "sweep R6");
      end
      @(negedge clk);
      chk("R3 idle level after sweep", {31'd0, sck}, {31'd0, b_cpol});
    end

    // R8 loop-back over all modes, data-in driven with other data
    for (int m = 0; m < 8; m++) begin
      b_cpol = m[0]; b_cpha = m[1]; b_msb = m[2];
      tx = 32'hC0DE_0000 | (m * 32'h1111);
      configure(1'b1, 1'b0, 4'd11, 4'd1);
      xfer(tx, ~tx, 12, 1'b1, 1'b1, "R8 loopback");
    end

    // R2 divider: measure one half period
    b_cpol = 1'b0; b_cpha = 1'b0; b_msb = 1'b1;
    for (int k = 0; k < 4; k++) begin
      logic       dv;
      logic [3:0] pm;
      dv = k[1];
      pm = (k[0]) ? 4'd15 : 4'd2;
      configure(1'b0, dv, 4'd3, pm);
      bus_wr(3'd3, 32'h0000_000A);
      @(sck); t0 = cyc;
      @(sck); t1 = cyc;
      chk("R2 half period", t1 - t0, 2 * (pm + 1) * (dv ? 16 : 1));
      wait_ne(seen);
      bus_wr(3'd1, 32'h0000_0300);
    end

    // R9 events, mask and interrupt
    b_cpol = 1'b1; b_cpha = 1'b1; b_msb = 1'b0;
    configure(1'b0, 1'b0, 4'd7, 4'd0);
    xfer(32'h0000_00A5, 32'h0000_003C, 8, 1'b0, 1'b0, "R9 setup");
    bus_rd(3'd1, r); chk("R10 not-full after load", r, 32'h0000_0300);
    chk("R9 irq masked off", {31'd0, irq}, 32'd0);
    bus_wr(3'd2, 32'h0000_0200);
    @(negedge clk);
    chk("R9 irq on mask", {31'd0, irq}, 32'd1);
    bus_wr(3'd1, 32'h0000_0100);
    bus_rd(3'd1, r); chk("R9 clear only not-full", r, 32'h0000_0200);
    bus_wr(3'd1, 32'h0000_0200);
    @(negedge clk);
    bus_rd(3'd1, r); chk("R9 events cleared", r, 32'd0);
    chk("R9 irq dropped", {31'd0, irq}, 32'd0);
    bus_wr(3'd2, 32'd0);

    // R10 holding buffer: back-to-back words, third write dropped
    b_cpol = 1'b0; b_cpha = 1'b0; b_msb = 1'b1;
    configure(1'b1, 1'b0, 4'd15, 4'd3);
    bus_wr(3'd3, 32'h0000_1357);
    repeat (2) @(negedge clk);
    bus_wr(3'd3, 32'h0000_2468);
    bus_wr(3'd3, 32'h0000_BEEF);
    bus_rd(3'd1, r); chk("R10 not-full cleared by accepted write", r, 32'd0);
    wait_ne(seen);
    chk("R10 first done", {31'd0, seen}, 32'd1);
    bus_rd(3'd4, r); chk("R10 first word", r, 32'h0000_1357);
    bus_rd(3'd1, r); chk("R10 not-full when held word loads", r & 32'h100, 32'h100);
    bus_wr(3'd1, 32'h0000_0300);
    wait_ne(seen);
    bus_rd(3'd4, r); chk("R10 held word sent next", r, 32'h0000_2468);
    bus_wr(3'd1, 32'h0000_0300);
    repeat (600) @(negedge clk);
    bus_rd(3'd1, r); chk("R10 full-buffer write dropped", r, 32'd0);

    // R11 abandon in flight
    b_cpol = 1'b1; b_cpha = 1'b0; b_msb = 1'b1;
    configure(1'b0, 1'b0, 4'd0, 4'd3);
    slv_cnt = 0; slv_idx = 1; slv_n = 32; slv_word = 32'h0; slv_on = 1'b1;
    bus_wr(3'd3, 32'hFFFF_0000);
    repeat (60) @(negedge clk);
    bus_wr(3'd0, mw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 4'd3));
    repeat (3) @(negedge clk);
    chk("R11 sck idle after stop", {31'd0, sck}, 32'd1);
    chk("R11 character partial", {31'd0, (slv_cnt > 0 && slv_cnt < 32)}, 32'd1);
    repeat (100) @(negedge clk);
    bus_rd(3'd1, r); chk("R11 no not-empty after abandon", r & 32'h200, 32'd0);
    bus_wr(3'd0, mw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd3));
    repeat (400) @(negedge clk);
    slv_on = 1'b0;
    bus_rd(3'd1, r); chk("R11 nothing resumes", r & 32'h200, 32'd0);
    chk("R11 sck idle after resume", {31'd0, sck}, 32'd1);

    // R11 writes while stopped, and master clear
    bus_wr(3'd1, 32'h0000_0300);
    bus_wr(3'd0, mw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd7, 4'd0));
    bus_wr(3'd3, 32'h0000_0055);
    bus_wr(3'd0, mw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 4'd7, 4'd0));
    repeat (200) @(negedge clk);
    bus_rd(3'd1, r); chk("R11 tx write while stopped dropped", r, 32'd0);
    bus_wr(3'd0, mw(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7, 4'd0));
    bus_wr(3'd3, 32'h0000_0055);
    repeat (200) @(negedge clk);
    bus_rd(3'd1, r); chk("R11 no run without master", r, 32'd0);
    chk("R11 sck idle without master", {31'd0, sck}, 32'd1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule